// File: doc/BRIEF.md
# Timed Configuration-Bit Read Window

This block sits on a CPU's program-memory load path and can, for a few cycles, swap flash data for the device's non-volatile configuration bits. Firmware arms it by writing a control register. The write must set both the self-program enable bit and the configuration-read enable bit. The next program-memory load that lands inside the short window gets back either the fuse low byte or the two lock bits. The byte address of that load picks which one is returned. Outside the window, a load passes flash data through unchanged.

The arm bits do not stay set. They clear when a redirected load completes, when a store-program strobe consumes them, or when the cycle window runs out. An EEPROM write in progress freezes the control register and switches the redirection off. Firmware can see that busy state in the status byte, so it can test it before writing.

Top module: `cfg_read_window`

## Requirements
- R1: A control write sets the self-program arm (`ctl_wdata` bit 0) and the configuration-read arm (`ctl_wdata` bit 3). The read arm is set only when bit 0 is also written as 1. The two arms are visible in the next cycle on `ctl_rdata` bits 0 and 3.
- R2: Take the control write cycle as cycle 0, with both arms written. A load in cycle 1, 2 or 3 is redirected to configuration data. Cycle 0 is the write cycle itself.
- R3: A redirected load with `ld_addr` = 0x0000 returns `fuse_lo`, with bit 7 returned in bit 7 and every other bit in its own place.
- R4: A redirected load with `ld_addr` = 0x0001 returns 0b111111 in bits 7..2, `lock_bits[1]` in bit 1 and `lock_bits[0]` in bit 0.
- R5: A redirected load to any other address returns 0xFF. All 16 address bits, bit 0 included, take part in the decode.
- R6: A redirected load clears both arm bits, as seen in the next cycle.
- R7: With both arms set and no load, both arms read 0 from cycle 4 onward, and loads return flash data again.
- R8: With only the self-program arm written, that arm reads 1 in cycles 1 to 4 and 0 from cycle 5 onward.
- R9: A store-program strobe (`st_valid`) while the self-program arm is set clears both arms. A load after it returns flash data.
- R10: While `ee_busy` is 1, control writes are ignored. Loads also return flash data and leave the arm bits as they were.
- R11: `ctl_rdata` bit 7 follows `ee_busy` in the same cycle. Bits 6..4, 2 and 1 read 0.
- R12: When the block is not armed, `ld_data` equals `flash_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears both arms |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data (bit 0 self-program, bit 3 config read) |
| ctl_rdata | output | 8 | Status: arms in bits 0 and 3, EEPROM busy in bit 7 |
| ld_valid | input | 1 | Program-memory load strobe |
| ld_addr | input | 16 | Byte address of the load |
| st_valid | input | 1 | Store-program strobe |
| flash_rdata | input | 8 | Flash byte for the current load |
| fuse_lo | input | 8 | Fuse low byte |
| lock_bits | input | 2 | Lock bits (bit 1 = second, bit 0 = first) |
| ee_busy | input | 1 | EEPROM write in progress |
| ld_data | output | 8 | Load result |

## Verification
The hardest points to reach from the ports are the edges of the window. These are a load in exactly cycle 3 versus cycle 4, and the self-program arm's last live cycle 4 versus cycle 5. Each needs a control write followed by an exact number of idle clocks. The bench sweeps the delay from the arming write to the load over cycles 1 to 5 for every address class. It also sweeps the delay to the status sample for both arm modes. An EEPROM-busy interval is placed over an armed window to show that the arms survive it untouched.

// File: rtl/cfg_read_window.sv
module cfg_read_window #(
  parameter int LOAD_WIN  = 3,
  parameter int STORE_WIN = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic [7:0]  ctl_wdata,
  output logic [7:0]  ctl_rdata,
  input  logic        ld_valid,
  input  logic [15:0] ld_addr,
  input  logic        st_valid,
  input  logic [7:0]  flash_rdata,
  input  logic [7:0]  fuse_lo,
  input  logic [1:0]  lock_bits,
  input  logic        ee_busy,
  output logic [7:0]  ld_data
);
  localparam int CW = $clog2(STORE_WIN + 1);

  logic          spm_en, rd_en;
  logic [CW-1:0] cnt;

  wire           armed    = spm_en & rd_en;
  wire           wr_ok    = ctl_we & ~ee_busy;
  wire           redirect = ld_valid & armed & ~ee_busy;
  wire           consume  = redirect | (st_valid & spm_en);
  wire [CW-1:0]  lim      = rd_en ? CW'(LOAD_WIN - 1) : CW'(STORE_WIN - 1);
  wire           expire   = spm_en & (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spm_en <= 1'b0;
      rd_en  <= 1'b0;
      cnt    <= '0;
    end else if (wr_ok) begin
      spm_en <= ctl_wdata[0];
      rd_en  <= ctl_wdata[0] & ctl_wdata[3];
      cnt    <= '0;
    end else if (consume | expire) begin
      spm_en <= 1'b0;
      rd_en  <= 1'b0;
      cnt    <= '0;
    end else if (spm_en) begin
      cnt    <= cnt + 1'b1;
    end
  end

  logic [7:0] cfg_byte;
  always_comb begin
    case (ld_addr)
      16'h0000: cfg_byte = fuse_lo;
      16'h0001: cfg_byte = {6'h3f, lock_bits};
      default:  cfg_byte = 8'hff;
    endcase
  end

  assign ld_data   = redirect ? cfg_byte : flash_rdata;
  assign ctl_rdata = {ee_busy, 3'b000, rd_en, 2'b00, spm_en};

  assert_rd_needs_spm_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> spm_en);
  assert_lock_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && ld_addr == 16'h0001) |-> ld_data[7:2] == 6'h3f);
  assert_load_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !ctl_we) |=> (!spm_en && !rd_en));
  assert_load_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> cnt < CW'(LOAD_WIN));
  assert_store_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    spm_en |-> cnt < CW'(STORE_WIN));
  assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_busy && ctl_we && !spm_en) |=> !spm_en);
  assert_pass_through_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!spm_en && ld_valid) |-> ld_data == flash_rdata);
endmodule

// File: tb/test_cfg_read_window.sv
module test_cfg_read_window;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic ctl_we = 0, ld_valid = 0, st_valid = 0, ee_busy = 0;
  logic [7:0] ctl_wdata = 0, flash_rdata = 8'h5a, fuse_lo = 8'h00, ctl_rdata, ld_data;
  logic [15:0] ld_addr = 0;
  logic [1:0] lock_bits = 0;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_read_window i_cfg_read_window (.*);

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic arm(input logic [7:0] v);
    ctl_we = 1; ctl_wdata = v; cyc(); ctl_we = 0;
  endtask

  function automatic logic [7:0] cfg_of(input logic [15:0] a);
    if (a == 16'h0000) return fuse_lo;
    if (a == 16'h0001) return {6'b111111, lock_bits};
    return 8'hff;
  endfunction

  task automatic load_at(input int d, input logic [15:0] a, input string req);
    logic [7:0] e;
    arm(8'h09);
    for (int i = 1; i < d; i++) cyc();
    ld_valid = 1; ld_addr = a; flash_rdata = 8'h3c ^ a[7:0]; #1;
    e = (d <= 3) ? cfg_of(a) : flash_rdata;
    chk(req, ld_data, e);
    cyc(); ld_valid = 0; #1;
    chk("R6", ctl_rdata, 8'h00);
  endtask

  initial begin
    cyc(); cyc(); #1;
    chk("R11 reset", ctl_rdata, 8'h00);
    rst_n = 1; cyc();
    ld_valid = 1; ld_addr = 0; #1; chk("R12", ld_data, flash_rdata); ld_valid = 0;

    for (int f = 0; f < 256; f++) begin
      fuse_lo = f[7:0]; load_at(1, 16'h0000, "R3");
    end
    for (int l = 0; l < 4; l++) begin
      lock_bits = l[1:0]; load_at(2, 16'h0001, "R4");
    end
    fuse_lo = 8'ha7; lock_bits = 2'b10;
    for (int d = 1; d <= 5; d++) begin
      load_at(d, 16'h0000, "R2 R7 fuse");
      load_at(d, 16'h0001, "R2 R7 lock");
      load_at(d, 16'h0100, "R5 hi");
      load_at(d, 16'h0003, "R5 odd");
      load_at(d, 16'h0002, "R5 even");
    end

    for (int d = 1; d <= 6; d++) begin
      arm(8'h09);
      for (int i = 1; i < d; i++) cyc();
      #1; chk("R7 timeout", ctl_rdata, (d <= 3) ? 8'h09 : 8'h00);
      cyc(); cyc(); cyc(); cyc();
    end
    for (int d = 1; d <= 6; d++) begin
      arm(8'h01);
      for (int i = 1; i < d; i++) cyc();
      #1; chk("R8", ctl_rdata, (d <= 4) ? 8'h01 : 8'h00);
      cyc(); cyc(); cyc(); cyc(); cyc();
    end
    arm(8'h08); #1; chk("R1 rd alone", ctl_rdata, 8'h00);
    arm(8'h09); #1; chk("R1 both", ctl_rdata, 8'h09);
    cyc(); cyc(); cyc();

    arm(8'h09); st_valid = 1; cyc(); st_valid = 0; #1;
    chk("R9 cleared", ctl_rdata, 8'h00);
    ld_valid = 1; ld_addr = 0; #1; chk("R9 flash", ld_data, flash_rdata);
    cyc(); ld_valid = 0;

    ee_busy = 1; #1; chk("R11 busy", ctl_rdata, 8'h80);
    arm(8'h09); #1; chk("R10 write", ctl_rdata, 8'h80);
    ee_busy = 0; arm(8'h09); ee_busy = 1;
    ld_valid = 1; ld_addr = 0; #1; chk("R10 load", ld_data, flash_rdata);
    cyc(); ld_valid = 0; ee_busy = 0; #1;
    chk("R10 kept", ctl_rdata, 8'h09);
    ld_valid = 1; #1; chk("R10 after", ld_data, fuse_lo);
    cyc(); ld_valid = 0; #1; chk("R6 after", ctl_rdata, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule